// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Bank

This block is a bank of general-purpose pins behind a small word-addressed register port. Software drives pins through an output latch and a per-pin direction mask. It observes pins through a synchronized copy of the pad inputs. The pad side is split into three vectors: `pad_in`, `pad_out` and `pad_oe`.

Each pin can also flag events. Three per-pin type bits choose one of five trigger modes: falling edge, rising edge, either edge, low level or high level. A detected event sets a sticky status bit, and software clears that bit by writing a one to it. One bank interrupt line is raised while any status bit is set whose per-pin enable is also set.

The register port is word addressed, and reads are combinational. The register offsets are:

| Offset | Register | Access |
|---|---|---|
| 0 | pin level / output latch | read returns the synchronized pad level; write loads the output latch |
| 1 | latch readback | read only |
| 2 | direction | read/write |
| 3 | interrupt enable | read/write |
| 4 | type bit 0 | read/write |
| 5 | type bit 1 | read/write |
| 6 | type bit 2 | read/write |
| 7 | status | read; write one to clear |

Top module: `gpiob_top`

## Requirements
- R1: A read at offset 0 returns the pad level after a two-flop synchronizer. This holds whatever the latch or direction holds. A pad change driven before clock edge k becomes readable after edge k+1 and not earlier.
- R2: A write to offset 0 loads the output latch. `pad_out` equals the latch. A read at offset 1 returns the latch exactly, and a write to offset 1 changes nothing.
- R3: The direction register at offset 2 drives `pad_oe`. A bit value of 1 means the pin is an output and 0 means it is an input.
- R4: When type bit 1 is 0, a pin is edge-triggered on its synchronized samples. Type bits (t2,t1,t0) = 000 selects the falling edge. The value 001 selects the rising edge. Any value with t2=1 and t1=0 selects both edges. A level that does not change never triggers.
- R5: When type bit 1 is 1, a pin is level-triggered. Type bit 0 gives the active level: 010 is low and 011 is high. The status bit is set again on every cycle that the level stays active.
- R6: Status bits at offset 7 are sticky. Writing 1 clears a bit. Writing 0 leaves the bit unchanged. When a new event and a clear fall in the same cycle, the event wins.
- R7: `irq` is high exactly when some status bit and its enable bit at offset 3 are both 1. The enable mask does not stop status capture.
- R8: Reset clears the latch, direction, enable, the three type registers and status. Reads at offsets 8 to 15 return 0.
- R9: An edge at the pad becomes visible in status after edge k+2, where the pad change was driven before clock edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register word offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational on `addr` |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output data (latch) |
| pad_oe | output | 32 | Pad output enable (direction) |
| irq | output | 1 | Bank interrupt |

## Verification
The bench gives every trigger encoding a matching transition and also a non-matching transition or a steady level. A decoder that confuses 100 with falling edge, or that lets a level mode fire at its inactive level, therefore leaves a wrong status bit. The bench reads the level register one edge too early and then at the right edge. A design that skips a synchronizer stage, or adds an extra one, shows up at one of those two reads. The level-mode test clears the status bit while the pin is still active and expects the bit to stay set. A design that lets the clear beat the new event would read 0 there. The interrupt test sets status with the enable mask at 0 and expects `irq` low, so an ungated interrupt shows up as well.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_LEVEL = 4'd0,
        RA_LATCH = 4'd1,
        RA_DIR   = 4'd2,
        RA_IEN   = 4'd3,
        RA_TYP0  = 4'd4,
        RA_TYP1  = 4'd5,
        RA_TYP2  = 4'd6,
        RA_STAT  = 4'd7
    } reg_addr_e;

    typedef struct packed {
        logic is_level;
        logic both;
        logic pol;
    } trig_cfg_t;

    function automatic trig_cfg_t decode_trig(logic t2, logic t1, logic t0);
        trig_cfg_t c;
        c.is_level = t1;
        c.both     = t2 & ~t1;
        c.pol      = t0;
        return c;
    endfunction

    function automatic logic pin_hit(trig_cfg_t c, logic cur, logic prev);
        logic h;
        if (c.is_level)
            h = (cur == c.pol);
        else if (c.both)
            h = cur ^ prev;
        else if (c.pol)
            h = cur & ~prev;
        else
            h = ~cur & prev;
        return h;
    endfunction

endpackage

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
    parameter int NPINS = 32,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] prev
);
    localparam int NSTG = DEPTH + 1;

    logic [NPINS-1:0] stg [NSTG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSTG; i++) stg[i] <= '0;
        end else begin
            stg[0] <= pad_in;
            for (int i = 1; i < NSTG; i++) stg[i] <= stg[i-1];
        end
    end

    assign level = stg[DEPTH-1];
    assign prev  = stg[DEPTH];

    p_stage_shift_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (prev == $past(level)));

endmodule

// File: rtl/gpiob_detect.sv
module gpiob_detect
    import gpiob_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] typ0,
    input  logic [NPINS-1:0] typ1,
    input  logic [NPINS-1:0] typ2,
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] prev,
    output logic [NPINS-1:0] hit
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        trig_cfg_t cfg;
        assign cfg    = decode_trig(typ2[i], typ1[i], typ0[i]);
        assign hit[i] = pin_hit(cfg, level[i], prev[i]);

        always_comb begin
            if (!typ1[i] && (level[i] == prev[i]))
                p_no_edge_when_steady_r4: assert (!hit[i]);
        end
    end

endmodule

// File: rtl/gpiob_regs.sv
module gpiob_regs
    import gpiob_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  level,
    input  logic [NPINS-1:0]  hit,
    output logic [NPINS-1:0]  rdata,
    output logic [NPINS-1:0]  latch,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  ien,
    output logic [NPINS-1:0]  typ0,
    output logic [NPINS-1:0]  typ1,
    output logic [NPINS-1:0]  typ2,
    output logic [NPINS-1:0]  stat
);
    logic [NPINS-1:0] clr;
    logic             stat_wr;

    assign stat_wr = wr_en && (addr == RA_STAT);
    assign clr     = stat_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch <= '0;
            dir   <= '0;
            ien   <= '0;
            typ0  <= '0;
            typ1  <= '0;
            typ2  <= '0;
            stat  <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    RA_LEVEL: latch <= wdata;
                    RA_DIR:   dir   <= wdata;
                    RA_IEN:   ien   <= wdata;
                    RA_TYP0:  typ0  <= wdata;
                    RA_TYP1:  typ1  <= wdata;
                    RA_TYP2:  typ2  <= wdata;
                    default:  ;
                endcase
            end
            stat <= (stat & ~clr) | hit;
        end
    end

    always_comb begin
        case (addr)
            RA_LEVEL: rdata = level;
            RA_LATCH: rdata = latch;
            RA_DIR:   rdata = dir;
            RA_IEN:   rdata = ien;
            RA_TYP0:  rdata = typ0;
            RA_TYP1:  rdata = typ1;
            RA_TYP2:  rdata = typ2;
            RA_STAT:  rdata = stat;
            default:  rdata = '0;
        endcase
    end

    p_w1c_clear_r6: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((stat & $past(wdata & ~hit)) == '0));

    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> (($past(stat) & ~stat) == '0));

    p_capture_r9: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((stat & $past(hit)) == $past(hit)));

endmodule

// File: rtl/gpiob_top.sv
module gpiob_top
    import gpiob_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    logic [NPINS-1:0] level, prev, hit;
    logic [NPINS-1:0] latch, dir, ien, typ0, typ1, typ2, stat;

    gpiob_sync #(.NPINS(NPINS), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .level(level), .prev(prev)
    );

    gpiob_detect #(.NPINS(NPINS)) u_detect (
        .typ0(typ0), .typ1(typ1), .typ2(typ2),
        .level(level), .prev(prev), .hit(hit)
    );

    gpiob_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .level(level), .hit(hit), .rdata(rdata),
        .latch(latch), .dir(dir), .ien(ien),
        .typ0(typ0), .typ1(typ1), .typ2(typ2), .stat(stat)
    );

    assign pad_out = latch;
    assign pad_oe  = dir;
    assign irq     = |(stat & ien);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

    p_oe_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == RA_DIR) |=> $stable(pad_oe));

    p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == RA_LEVEL) |=> $stable(pad_out));

endmodule

// File: tb/gpiob_top_bench.sv
module gpiob_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [3:0] A_LVL = 4'd0, A_RB = 4'd1, A_DIR = 4'd2, A_IEN = 4'd3,
                           A_T0 = 4'd4, A_T1 = 4'd5, A_T2 = 4'd6, A_ST = 4'd7;

    // {t2,t1,t0, pad before, pad after, expected status bit 0}
    localparam int NV = 11;
    localparam logic [5:0] VEC [NV] = '{
        6'b000_1_0_1, 6'b000_0_1_0, 6'b001_0_1_1, 6'b001_1_0_0,
        6'b101_0_1_1, 6'b101_1_0_1, 6'b100_0_1_1,
        6'b010_1_0_1, 6'b011_0_1_1, 6'b011_0_0_0, 6'b010_1_1_0
    };

    gpiob_top u_gpiob_top (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R8: reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[3:0], v);
            chk("R8 reset reg", v, 32'h0);
        end
        chk("R8 reset irq", {31'b0, irq}, 32'h0);
        rd(4'd11, v); chk("R8 unmapped read", v, 32'h0);

        // R2: latch, readback, pad_out; write to readback ignored
        wr(A_LVL, 32'hA5A5_0F0F);
        rd(A_RB, v); chk("R2 readback", v, 32'hA5A5_0F0F);
        chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
        wr(A_RB, 32'h1111_2222);
        rd(A_RB, v); chk("R2 readback write ignored", v, 32'hA5A5_0F0F);
        chk("R2 pad_out after readback write", pad_out, 32'hA5A5_0F0F);

        // R3: direction
        wr(A_DIR, 32'hFFFF_0000);
        chk("R3 pad_oe", pad_oe, 32'hFFFF_0000);
        rd(A_DIR, v); chk("R3 dir read", v, 32'hFFFF_0000);
        wr(A_DIR, 32'hFFFF_FFFF);

        // R1: level read is pad through 2 flops, not latch
        pad_in = 32'h1234_5678;
        @(posedge clk); @(negedge clk);
        rd(A_LVL, v); chk("R1 level after one edge", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(A_LVL, v); chk("R1 level after two edges", v, 32'h1234_5678);

        // settle pads to 0, clear all status
        pad_in = '0;
        cyc(5);
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); chk("R6 clear all", v, 32'h0);

        // R4/R5/R9: trigger mode table on pin 0
        for (int k = 0; k < NV; k++) begin
            wr(A_T0, {31'b0, VEC[k][3]});
            wr(A_T1, {31'b0, VEC[k][4]});
            wr(A_T2, {31'b0, VEC[k][5]});
            pad_in[0] = VEC[k][2];
            cyc(5);
            wr(A_ST, 32'hFFFF_FFFF);
            pad_in[0] = VEC[k][1];
            cyc(4);
            rd(A_ST, v);
            chk($sformatf("R4 R5 trigger vector %0d", k), {31'b0, v[0]}, {31'b0, VEC[k][0]});
        end

        // R9 timing + R6 write-0 + R7 irq gating, rising edge on pin 0
        wr(A_T0, 32'h1); wr(A_T1, 32'h0); wr(A_T2, 32'h0);
        pad_in[0] = 1'b0;
        cyc(5);
        wr(A_ST, 32'hFFFF_FFFF);
        pad_in[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(A_ST, v); chk("R9 status not yet after k+1", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(A_ST, v); chk("R9 status after k+2", v, 32'h1);
        wr(A_ST, 32'h0);
        rd(A_ST, v); chk("R6 write zero keeps bit", v, 32'h1);
        chk("R7 irq masked", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h1);
        chk("R7 irq enabled", {31'b0, irq}, 32'h1);
        wr(A_ST, 32'h1);
        rd(A_ST, v); chk("R6 write one clears", v, 32'h0);
        chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h0);

        // R5/R6: level high on pin 3, clear loses while active
        wr(A_T0, 32'h8); wr(A_T1, 32'h8); wr(A_T2, 32'h0);
        pad_in[3] = 1'b1;
        cyc(4);
        wr(A_ST, 32'h8);
        rd(A_ST, v); chk("R5 level reasserts after clear", {31'b0, v[3]}, 32'h1);
        pad_in[3] = 1'b0;
        cyc(4);
        wr(A_ST, 32'h8);
        rd(A_ST, v); chk("R5 clear after inactive", {31'b0, v[3]}, 32'h0);

        finish_run();
    end

endmodule